// File: doc/BRIEF.md
# SPI EEPROM Host Write Sequencer

This block is the host-side controller for a serial EEPROM on an SPI bus. A client hands it a request (read or write), a 16-bit start address and a byte count. Write data is then streamed in over a valid/ready handshake, and read data is streamed out over a valid/ready handshake. The sequencer produces chip select, a divided serial clock in mode 0 (idle low, sample on the rising edge), and the outgoing data line. It samples the incoming data line.

For a write, the block issues a write-enable command in a frame of its own. It then sends a second frame with the write command, the address and the data. Next it polls the device status in further frames until the busy bit clears. A write request that runs past the end of a 16-byte page is cut into page-aligned pieces, and each piece goes through the whole sequence. A read is one frame: command, address, and then as many bytes as requested. A one-cycle completion pulse marks the end of a request. A polling timeout sets an error flag instead.

Top module: `spiEepromSeq`

## Requirements
- R1: After reset and while idle, csN is 1, sck is 0, reqReady is 1, and done, err, rdValid and wrReady are 0.
- R2: Every write frame is preceded by a separate frame carrying only 8'h06. The write frame itself is 8'h02, then the address high byte, then the address low byte, then the data. All bytes go out most significant bit first.
- R3: No write frame carries data past the end of its 16-byte page (address bits [3:0] wrap point). A request is split into page-aligned frames, one per page touched, and bytes outside the request stay unchanged.
- R4: After each write frame, the block sends frames of 8'h05 followed by one status read. It repeats these until status bit 0 reads 0, and only then starts the next frame.
- R5: done pulses for exactly one cycle, and for a write only after the last status read of the last page reports bit 0 as 0.
- R6: A read is one frame: 8'h03, the address high byte, the address low byte, then reqLen bytes delivered in address order on rdData. Page boundaries do not split it.
- R7: While rdValid is 1 and rdReady is 0, rdValid stays 1, rdData holds, and sck does not toggle.
- R8: wrReady is 1 only in the data phase of a write frame. Each wrValid/wrReady handshake consumes exactly one byte, and wrReady is never 1 during a read.
- R9: Between two frames, csN stays high for at least CS_GAP clock cycles.
- R10: sck is low whenever csN is high. While shifting, its period is 2*CLK_DIV clock cycles.
- R11: If POLL_LIMIT consecutive status reads return bit 0 as 1, err goes to 1, no done is given, and the block returns to idle. err clears when the next request is accepted.
- R12: A request with reqLen of 0 gives a done pulse and produces no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block is idle and takes a request |
| reqWrite | input | 1 | 1 = write request, 0 = read request |
| reqAddr | input | 16 | Start byte address |
| reqLen | input | LEN_W | Number of bytes |
| wrData | input | 8 | Write byte from the client |
| wrValid | input | 1 | Write byte offered |
| wrReady | output | 1 | Write byte taken this cycle |
| rdData | output | 8 | Read byte to the client |
| rdValid | output | 1 | Read byte offered |
| rdReady | input | 1 | Client takes the read byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Status polling timed out |
| csN | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
The main function is tested with write requests of several shapes:
- a request that fills exactly one aligned page;
- a short request inside a page;
- requests that straddle one boundary, two boundaries, or start on the last byte of a page;
- a single-byte request.

Counting frames on the device model tells apart correct segmentation, a missing split, and an extra split. Reading the range back, and checking the byte just past its end, separates correct placement from wrap corruption. The directed cases cover the following: a zero-length request, a read held off by backpressure, and a device that never leaves busy. Together they separate the completion, stall and timeout paths.

// File: rtl/spiSeqPkg.sv
`timescale 1ns/1ps
package spiSeqPkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam int         BUSY_BIT = 0;

  typedef struct packed {
    logic       startByte;
    logic       csDrop;
    logic       csRaise;
    logic [7:0] txByte;
  } dpCtrl_t;

  typedef enum logic [3:0] {
    S_IDLE, S_WREN, S_WHDR, S_WDATA, S_POLL, S_RHDR, S_RDATA, S_RHOLD, S_GAP
  } seqState_t;
endpackage

// File: rtl/spiByteShifter.sv
`timescale 1ns/1ps
module spiByteShifter
  import spiSeqPkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtrl_t    ctrl,
  input  logic       miso,
  output logic       csN,
  output logic       sck,
  output logic       mosi,
  output logic       byteDone,
  output logic [7:0] rxByte
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [7:0]       shReg;
  logic [2:0]       bitCnt;
  logic [DIV_W-1:0] divCnt;
  logic             busy;

  assign mosi = shReg[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN      <= 1'b1;
      sck      <= 1'b0;
      shReg    <= '0;
      bitCnt   <= '0;
      divCnt   <= '0;
      busy     <= 1'b0;
      byteDone <= 1'b0;
      rxByte   <= '0;
    end else begin
      byteDone <= 1'b0;
      if (ctrl.csDrop)  csN <= 1'b0;
      if (ctrl.csRaise) csN <= 1'b1;
      if (ctrl.startByte) begin
        shReg  <= ctrl.txByte;
        busy   <= 1'b1;
        bitCnt <= '0;
        divCnt <= '0;
      end else if (busy) begin
        if (divCnt == DIV_W'(CLK_DIV - 1)) begin
          divCnt <= '0;
          if (!sck) begin
            sck    <= 1'b1;
            rxByte <= {rxByte[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bitCnt == 3'd7) begin
              busy     <= 1'b0;
              byteDone <= 1'b1;
            end else begin
              shReg  <= {shReg[6:0], 1'b0};
              bitCnt <= bitCnt + 3'd1;
            end
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spiSeqCtrl.sv
`timescale 1ns/1ps
module spiSeqCtrl
  import spiSeqPkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int LEN_W      = 12,
  parameter int CS_GAP     = 4,
  parameter int POLL_LIMIT = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [15:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [7:0]       wrData,
  input  logic             wrValid,
  output logic             wrReady,
  output logic [7:0]       rdData,
  output logic             rdValid,
  input  logic             rdReady,
  output logic             done,
  output logic             err,
  input  logic             byteDone,
  input  logic [7:0]       rxByte,
  output dpCtrl_t          dp
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int GAP_W  = $clog2(CS_GAP + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  seqState_t        state, retState;
  logic             inFlight;
  logic [1:0]       byteIdx;
  logic [15:0]      curAddr;
  logic [LEN_W-1:0] remain;
  logic [OFS_W:0]   segLeft, pageRoom, segLen;
  logic [GAP_W-1:0] gapCnt;
  logic [POLL_W-1:0] pollCnt;
  logic [7:0]       tx;
  logic             go, frameEnd;

  assign reqReady = (state == S_IDLE);
  assign pageRoom = (OFS_W+1)'(PAGE_BYTES) - {1'b0, curAddr[OFS_W-1:0]};
  assign segLen   = (remain < LEN_W'(pageRoom)) ? remain[OFS_W:0] : pageRoom;

  always_comb begin
    tx       = 8'h00;
    frameEnd = 1'b0;
    wrReady  = 1'b0;
    case (state)
      S_WREN:  begin tx = OP_WREN; frameEnd = byteDone; end
      S_WHDR:  tx = (byteIdx == 2'd0) ? OP_WRITE : (byteIdx == 2'd1) ? curAddr[15:8] : curAddr[7:0];
      S_RHDR:  tx = (byteIdx == 2'd0) ? OP_READ  : (byteIdx == 2'd1) ? curAddr[15:8] : curAddr[7:0];
      S_WDATA: begin
        tx       = wrData;
        wrReady  = !inFlight;
        frameEnd = byteDone && (segLeft == (OFS_W+1)'(1));
      end
      S_POLL:  begin
        tx       = (byteIdx == 2'd0) ? OP_RDSR : 8'h00;
        frameEnd = byteDone && (byteIdx == 2'd1);
      end
      S_RHOLD: frameEnd = rdReady && (remain == LEN_W'(1));
      default: ;
    endcase
    go = (state inside {S_WREN, S_WHDR, S_WDATA, S_POLL, S_RHDR, S_RDATA}) && !inFlight
         && (state != S_WDATA || wrValid);
    dp.startByte = go;
    dp.csDrop    = go;
    dp.csRaise   = frameEnd;
    dp.txByte    = tx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; retState <= S_IDLE; inFlight <= 1'b0; byteIdx <= '0;
      curAddr <= '0; remain <= '0; segLeft <= '0; gapCnt <= '0; pollCnt <= '0;
      rdData <= '0; rdValid <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go)       inFlight <= 1'b1;
      if (byteDone) inFlight <= 1'b0;
      case (state)
        S_IDLE: if (reqValid) begin
          err     <= 1'b0;
          curAddr <= reqAddr;
          remain  <= reqLen;
          byteIdx <= '0;
          if (reqLen == '0) done <= 1'b1;
          else state <= reqWrite ? S_WREN : S_RHDR;
        end
        S_WREN: if (byteDone) begin
          gapCnt <= '0; retState <= S_WHDR; state <= S_GAP;
        end
        S_WHDR: if (byteDone) begin
          if (byteIdx == 2'd2) begin
            state <= S_WDATA; segLeft <= segLen; byteIdx <= '0;
          end else byteIdx <= byteIdx + 2'd1;
        end
        S_WDATA: if (byteDone) begin
          curAddr <= curAddr + 16'd1;
          remain  <= remain - LEN_W'(1);
          segLeft <= segLeft - (OFS_W+1)'(1);
          if (frameEnd) begin
            gapCnt <= '0; pollCnt <= '0; retState <= S_POLL; state <= S_GAP;
          end
        end
        S_POLL: if (byteDone) begin
          if (byteIdx == 2'd0) byteIdx <= 2'd1;
          else begin
            byteIdx <= '0; gapCnt <= '0; state <= S_GAP;
            if (!rxByte[BUSY_BIT]) begin
              if (remain == '0) begin done <= 1'b1; retState <= S_IDLE; end
              else retState <= S_WREN;
            end else if (pollCnt == POLL_W'(POLL_LIMIT - 1)) begin
              err <= 1'b1; retState <= S_IDLE;
            end else begin
              pollCnt <= pollCnt + POLL_W'(1); retState <= S_POLL;
            end
          end
        end
        S_RHDR: if (byteDone) begin
          if (byteIdx == 2'd2) begin state <= S_RDATA; byteIdx <= '0; end
          else byteIdx <= byteIdx + 2'd1;
        end
        S_RDATA: if (byteDone) begin
          rdData <= rxByte; rdValid <= 1'b1; state <= S_RHOLD;
        end
        S_RHOLD: if (rdReady) begin
          rdValid <= 1'b0;
          remain  <= remain - LEN_W'(1);
          if (frameEnd) begin
            done <= 1'b1; gapCnt <= '0; retState <= S_IDLE; state <= S_GAP;
          end else state <= S_RDATA;
        end
        S_GAP: if (gapCnt == GAP_W'(CS_GAP - 1)) state <= retState;
               else gapCnt <= gapCnt + GAP_W'(1);
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spiEepromSeq.sv
`timescale 1ns/1ps
module spiEepromSeq
  import spiSeqPkg::*;
#(
  parameter int CLK_DIV    = 2,
  parameter int CS_GAP     = 4,
  parameter int POLL_LIMIT = 64,
  parameter int LEN_W      = 12,
  parameter int PAGE_BYTES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [15:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [7:0]       wrData,
  input  logic             wrValid,
  output logic             wrReady,
  output logic [7:0]       rdData,
  output logic             rdValid,
  input  logic             rdReady,
  output logic             done,
  output logic             err,
  output logic             csN,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);
  dpCtrl_t    dpCtrl;
  logic       byteDone;
  logic [7:0] rxByte;

  spiSeqCtrl #(
    .PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W), .CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqLen(reqLen),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady),
    .done(done), .err(err), .byteDone(byteDone), .rxByte(rxByte), .dp(dpCtrl)
  );

  spiByteShifter #(.CLK_DIV(CLK_DIV)) shift_i (
    .clk(clk), .rstN(rstN), .ctrl(dpCtrl), .miso(miso),
    .csN(csN), .sck(sck), .mosi(mosi), .byteDone(byteDone), .rxByte(rxByte)
  );
endmodule

// File: rtl/spiEepromSeqChk.sv
`timescale 1ns/1ps
module spiEepromSeqChk #(
  parameter int CS_GAP = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       sck,
  input logic       reqReady,
  input logic       wrValid,
  input logic       wrReady,
  input logic       rdValid,
  input logic       rdReady,
  input logic [7:0] rdData,
  input logic       done,
  input logic       err
);
  int highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) highCnt <= CS_GAP;
    else if (csN) highCnt <= (highCnt < CS_GAP) ? highCnt + 1 : CS_GAP;
    else highCnt <= 0;
  end

  assert_sck_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);
  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> csN);
  assert_cs_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> highCnt >= CS_GAP);
  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData)));
  assert_rd_nosck_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> $stable(sck));
  assert_wr_inframe_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady) |-> !csN);
  assert_done_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

bind spiEepromSeq spiEepromSeqChk #(.CS_GAP(CS_GAP)) chk_i (.*);

// File: tb/spiEepromSeq_tb_top.sv
`timescale 1ns/1ps
module spiEepromSeq_tb_top;
  localparam int CLK_DIV = 2, CS_GAP = 3, POLL_LIMIT = 8, LEN_W = 12, BUSY_POLLS = 2;
  localparam int NV = 6;
  // {addr, len, seed}
  localparam logic [47:0] VEC [NV] = '{
    {16'h0000, 16'd16, 16'h0010}, {16'h0025, 16'd5, 16'h0040},
    {16'h003A, 16'd20, 16'h0060}, {16'h0100, 16'd40, 16'h0080},
    {16'h01FF, 16'd2,  16'h00C0}, {16'h0300, 16'd1,  16'h00E0}};

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0, wrValid = 0, rdReady = 0, miso = 0;
  logic [15:0] reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [7:0] wrData = '0;
  logic reqReady, wrReady, rdValid, done, err, csN, sck, mosi;
  logic [7:0] rdData;

  always #2.5 clk = ~clk;

  spiEepromSeq #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqLen(reqLen), .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady), .done(done), .err(err),
    .csN(csN), .sck(sck), .mosi(mosi), .miso(miso));

  int checks = 0, fails = 0, cycles = 0;
  int doneCnt = 0, doneBad = 0, wrBad = 0;
  bit opWrite = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [7:0] mem [0:4095];
  logic [7:0] pend [0:15];
  logic [7:0] rxSh = 0, txSh = 0, cmd = 0;
  logic [15:0] mAddr = 0;
  int bitCnt = 0, pendCnt = 0, busyLeft = 0, protoErr = 0, gapBad = 0, sckEdges = 0;
  int wrenFrames = 0, writeFrames = 0, readFrames = 0, rdsrFrames = 0;
  bit wel = 0, stuck = 0, lastWip = 0;
  realtime lastRise = 0, lastSck = 0, sckPer = 0;

  initial for (int i = 0; i < 4096; i++) mem[i] = 8'hFF;

  always @(negedge csN) begin
    bitCnt = 0;
    if (($realtime - lastRise) < (CS_GAP * 5.0 - 0.01)) gapBad++;
  end

  always @(posedge csN) begin
    lastRise = $realtime;
    if (bitCnt >= 8) begin
      if (cmd == 8'h06) wel = 1;
      else if (cmd == 8'h02 && pendCnt > 0 && pendCnt <= 16 && bitCnt % 8 == 0) begin
        for (int k = 0; k < pendCnt; k++) mem[12'(int'(mAddr) + k)] = pend[k];
        wel = 0;
        busyLeft = stuck ? 1 : BUSY_POLLS;
      end else if (cmd == 8'h05 && busyLeft > 0 && !stuck) busyLeft--;
    end
  end

  always @(posedge sck) begin
    sckEdges++;
    if (!csN) begin
      if (bitCnt % 8 != 0) sckPer = $realtime - lastSck;
      lastSck = $realtime;
      rxSh = {rxSh[6:0], mosi};
      bitCnt++;
      if (bitCnt % 8 == 0) begin
        if (bitCnt == 8) begin
          cmd = rxSh; pendCnt = 0;
          if (busyLeft > 0 && rxSh != 8'h05) protoErr++;
          case (rxSh)
            8'h06: wrenFrames++;
            8'h02: begin writeFrames++; if (!wel) protoErr++; end
            8'h03: readFrames++;
            8'h05: begin rdsrFrames++; lastWip = (busyLeft != 0); txSh = {6'b0, wel, busyLeft != 0}; end
            default: protoErr++;
          endcase
        end else if (bitCnt == 16) mAddr[15:8] = rxSh;
        else if (bitCnt == 24) begin
          mAddr[7:0] = rxSh;
          if (cmd == 8'h03) begin txSh = mem[mAddr[11:0]]; mAddr++; end
        end else if (cmd == 8'h02) begin
          if (pendCnt >= 16 || int'(mAddr[3:0]) + pendCnt > 15) protoErr++;
          else pend[pendCnt] = rxSh;
          pendCnt++;
        end else if (cmd == 8'h03) begin txSh = mem[mAddr[11:0]]; mAddr++; end
        else if (cmd == 8'h05) txSh = {6'b0, wel, busyLeft != 0};
      end
    end
  end

  always @(negedge sck) if (!csN) begin
    miso <= txSh[7];
    txSh = {txSh[6:0], 1'b0};
  end

  // ---------------- monitors ----------------
  always @(posedge clk) begin
    cycles++;
    if (done) begin
      doneCnt++;
      if (opWrite) begin
        checks++;  // R5: completion only once device reported idle
        if (busyLeft != 0 || lastWip) begin
          fails++; doneBad++;
          $display("FAIL R5 done while busy actual=%0d expected=0", busyLeft);
        end
      end
    end
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=finish", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // ---------------- tasks ----------------
  task automatic sendReq(input bit w, input logic [15:0] a, input int n);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    opWrite = w;
    reqValid = 1; reqWrite = w; reqAddr = a; reqLen = LEN_W'(n);
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic doWrite(input logic [15:0] a, input int n, input logic [7:0] seed);
    sendReq(1, a, n);
    for (int i = 0; i < n; i++) begin
      bit took;
      wrValid = 1; wrData = seed + 8'(i);
      do begin took = wrReady; @(negedge clk); end while (!took);
    end
    wrValid = 0;
  endtask

  task automatic waitEnd(input int d0);
    for (int t = 0; t < 20000; t++) begin
      if (doneCnt != d0 || err) break;
      @(negedge clk);
    end
  endtask

  logic [7:0] rbuf [0:63];
  task automatic collect(input int n);
    int got = 0;
    rdReady = 1;
    for (int t = 0; t < 20000 && got < n; t++) begin
      if (rdValid) begin rbuf[got] = rdData; got++; end
      if (wrReady) wrBad++;
      @(negedge clk);
    end
    rdReady = 0;
  endtask

  // ---------------- sequence ----------------
  initial begin
    int d0, f0, w0, p0, r0, expF, a, rem, s, bad, e0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(csN === 1 && sck === 0, "R1 bus idle", {csN, sck}, 2'b10);
    chk(reqReady === 1 && done === 0 && err === 0 && rdValid === 0 && wrReady === 0,
        "R1 handshake idle", {reqReady, done, err, rdValid, wrReady}, 5'b10000);
    rstN = 1;
    repeat (3) @(negedge clk);
    chk(csN === 1 && reqReady === 1, "R1 after release", {csN, reqReady}, 2'b11);

    for (int v = 0; v < NV; v++) begin
      logic [15:0] va; int vl; logic [7:0] vs;
      va = VEC[v][47:32]; vl = int'(VEC[v][31:16]); vs = VEC[v][7:0];
      expF = 0; a = int'(va); rem = vl;
      while (rem > 0) begin
        s = (rem < 16 - a % 16) ? rem : 16 - a % 16;
        expF++; a += s; rem -= s;
      end
      d0 = doneCnt; f0 = writeFrames; w0 = wrenFrames; p0 = rdsrFrames; e0 = protoErr;
      doWrite(va, vl, vs);
      waitEnd(d0);
      chk(doneCnt == d0 + 1, "R5 write done", doneCnt - d0, 1);
      chk(writeFrames - f0 == expF, "R3 write frames", writeFrames - f0, expF);
      chk(wrenFrames - w0 == expF && protoErr == e0, "R2 enable per frame", wrenFrames - w0, expF);
      chk(rdsrFrames - p0 == expF * (BUSY_POLLS + 1), "R4 poll frames", rdsrFrames - p0, expF * (BUSY_POLLS + 1));
      chk(mem[12'(int'(va) + vl)] == 8'hFF, "R3 no wrap corruption", mem[12'(int'(va) + vl)], 8'hFF);
      // read back through the block
      d0 = doneCnt; r0 = readFrames;
      sendReq(0, va, vl);
      collect(vl);
      waitEnd(d0);
      bad = 0;
      for (int i = 0; i < vl; i++) if (rbuf[i] != vs + 8'(i)) bad++;
      chk(bad == 0, "R6 readback data", bad, 0);
      chk(readFrames - r0 == 1 && doneCnt == d0 + 1, "R6 single read frame", readFrames - r0, 1);
      if (v == 0) chk(sckPer > 19.9 && sckPer < 20.1, "R10 sck period", int'(sckPer), 20);
    end
    chk(wrBad == 0, "R8 no wrReady in read", wrBad, 0);

    // R12: zero-length request
    begin
      int c0;
      c0 = wrenFrames + writeFrames + readFrames + rdsrFrames;
      d0 = doneCnt;
      sendReq(1, 16'h0500, 0);
      repeat (4) @(negedge clk);
      chk(doneCnt == d0 + 1, "R12 zero length done", doneCnt - d0, 1);
      chk(wrenFrames + writeFrames + readFrames + rdsrFrames == c0, "R12 no frame",
          wrenFrames + writeFrames + readFrames + rdsrFrames - c0, 0);
    end

    // R7: read backpressure
    begin
      logic [7:0] held; int e1;
      d0 = doneCnt;
      rdReady = 0;
      sendReq(0, 16'h0000, 3);
      for (int t = 0; t < 2000 && !rdValid; t++) @(negedge clk);
      held = rdData; e1 = sckEdges;
      repeat (20) @(negedge clk);
      chk(rdValid === 1 && rdData == held, "R7 data held", rdData, held);
      chk(sckEdges == e1, "R7 sck stopped", sckEdges - e1, 0);
      collect(3);
      waitEnd(d0);
      chk(rbuf[0] == 8'h10 && rbuf[2] == 8'h12, "R7 order after stall", {rbuf[0], rbuf[2]}, 16'h1012);
    end

    // R11: polling timeout
    begin
      stuck = 1;
      d0 = doneCnt; p0 = rdsrFrames;
      doWrite(16'h0400, 1, 8'h5A);
      waitEnd(d0);
      repeat (CS_GAP + 3) @(negedge clk);
      chk(err === 1 && doneCnt == d0, "R11 error flag", {err, doneCnt - d0 == 0}, 2'b11);
      chk(rdsrFrames - p0 == POLL_LIMIT, "R11 poll count", rdsrFrames - p0, POLL_LIMIT);
      chk(reqReady === 1 && csN === 1, "R11 back to idle", {reqReady, csN}, 2'b11);
      stuck = 0; busyLeft = 0; lastWip = 0;
      sendReq(0, 16'h0000, 0);
      chk(err === 0, "R11 error cleared", err, 0);
    end

    repeat (10) @(negedge clk);
    chk(gapBad == 0, "R9 cs gap", gapBad, 0);
    chk(protoErr == 0, "R2 protocol", protoErr, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule